// File: doc/BRIEF.md
# VLIW Execute Packet Dispatcher

This block sits between program memory and the functional units of a wide-issue processor. It fetches a 256-bit group of eight 32-bit instruction slots, then splits that group into execute packets. Bit 0 of each instruction is its chain bit. A set chain bit ties the instruction to the one in the next slot. A clear chain bit closes the current packet.

One execute packet goes out per clock. Its instructions are packed onto the lowest output lanes, in their slot order, and each lane carries a valid flag. Downstream stalls the dispatcher by holding the ready input low. A new fetch group is requested only once the final packet of the current group has been accepted.

The slot that ends a group always closes its packet. If that slot still has its chain bit set, an error flag is raised for as long as the group is held.

Top module: `vliw_packet_dispatcher`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `fetch_req` is 1, `issue_valid` is all zeros and `chain_error` is 0. An asserted reset in the middle of a group drops that group and returns to requesting.
- R2: A fetch group is taken in on a clock edge where both `fetch_req` and `fetch_valid` are 1. In the next cycle `fetch_req` is 0 and the group's first execute packet is on the outputs.
- R3: Slot s occupies bits [32s+31:32s] of `fetch_data`, so slot 0 is bits [31:0]. Slots are scanned upward from the current start slot. A slot whose bit 0 is 1 chains to the next slot. A slot whose bit 0 is 0 ends the packet.
- R4: The packet's n instructions appear on lanes 0..n-1 in ascending slot order, with lane k at bits [32k+31:32k] of `issue_insn`. Lanes n..7 have valid 0 and an all-zero instruction word.
- R5: Each clock edge with `issue_ready` high and a packet presented retires exactly one packet. The next packet of the same group, which starts at the slot after the retired one, is presented in the following cycle.
- R6: The last slot always ends its packet, whatever its bit 0. `chain_error` is 1 for the whole time a group is held whose last slot has bit 0 set, and 0 otherwise.
- R7: `fetch_req` stays 0 while any packet of the group remains. It returns to 1 in the cycle after the group's final packet is accepted. `fetch_req` and any `issue_valid` bit are never high together.
- R8: While a packet is presented and `issue_ready` is 0, `issue_valid` and `issue_insn` hold their values and the dispatch position does not advance.
- R9: `fetch_valid` and `fetch_data` have no effect while `fetch_req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_req | output | 1 | Request for the next 256-bit group |
| fetch_valid | input | 1 | Program memory returns a group on `fetch_data` |
| fetch_data | input | 256 | Eight 32-bit instruction slots |
| issue_ready | input | 1 | Functional units accept the presented packet |
| issue_valid | output | 8 | Per-lane valid flags |
| issue_insn | output | 256 | Eight 32-bit lane instruction words |
| chain_error | output | 1 | The held group's last slot has its chain bit set |

## Verification
The bench sweeps all 256 chain-bit patterns of a group, which covers every split from one eight-wide packet to eight single-slot packets.

Each pattern tests the packing offset. A design that got the offset wrong would place instructions on the wrong lanes, or leave stale words on unused lanes.

Each pattern also tests the last-slot rule and the stall behaviour. A design that let a set chain bit in the last slot run on would never finish the group. A design that advanced during a stall would lose a packet. The bench also pushes stray fetch data into stall cycles, which a design that ignores `fetch_req` would capture as a new group. A reset in the middle of a group checks that the held packet is dropped.

// File: rtl/vliw_disp_pkg.sv
package vliw_disp_pkg;
   typedef enum logic {
      ST_FETCH = 1'b0,
      ST_ISSUE = 1'b1
   } disp_state_e;
endpackage

// File: rtl/vdisp_fetch_buffer.sv
module vdisp_fetch_buffer #(
   parameter int SLOTS = 8,
   parameter int IW    = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  load,
   input  logic [SLOTS*IW-1:0]   load_data,
   output logic [SLOTS*IW-1:0]   held_data,
   output logic [SLOTS-1:0]      chain_bits
);
   always_ff @(posedge clk) begin
      if (!rst_n)    held_data <= '0;
      else if (load) held_data <= load_data;
   end

   for (genvar s = 0; s < SLOTS; s++) begin : g_chain
      assign chain_bits[s] = held_data[s*IW];
   end

   AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (held_data == $past(load_data))); // R2
endmodule

// File: rtl/vdisp_boundary.sv
module vdisp_boundary #(
   parameter int SLOTS = 8,
   parameter int PW    = $clog2(SLOTS),
   parameter int CW    = PW + 1
) (
   input  logic [SLOTS-1:0] chain_bits,
   input  logic [PW-1:0]    start_pos,
   output logic [PW-1:0]    end_pos,
   output logic [CW-1:0]    count
);
   always_comb begin
      end_pos = PW'(SLOTS - 1);
      for (int i = SLOTS - 2; i >= 0; i--) begin
         if ((i >= int'(start_pos)) && !chain_bits[i]) end_pos = PW'(i);
      end
      count = CW'(end_pos) - CW'(start_pos) + CW'(1);
   end
endmodule

// File: rtl/vdisp_lane_map.sv
module vdisp_lane_map #(
   parameter int SLOTS  = 8,
   parameter int IW     = 32,
   parameter bit PACKED = 1'b1,
   parameter int PW     = $clog2(SLOTS),
   parameter int CW     = PW + 1
) (
   input  logic [SLOTS*IW-1:0] held_data,
   input  logic [PW-1:0]       start_pos,
   input  logic [PW-1:0]       end_pos,
   input  logic [CW-1:0]       count,
   input  logic                active,
   output logic [SLOTS-1:0]    lane_valid,
   output logic [SLOTS*IW-1:0] lane_insn
);
   logic [IW-1:0] words [SLOTS];

   for (genvar s = 0; s < SLOTS; s++) begin : g_words
      assign words[s] = held_data[s*IW +: IW];
   end

   for (genvar k = 0; k < SLOTS; k++) begin : g_lane
      if (PACKED) begin : g_packed
         logic [CW-1:0] idx;
         always_comb begin
            idx = CW'(start_pos) + CW'(k);
            lane_valid[k] = active && (CW'(k) < count);
            lane_insn[k*IW +: IW] = lane_valid[k] ? words[idx[PW-1:0]] : '0;
         end
      end else begin : g_aligned
         always_comb begin
            lane_valid[k] = active && (PW'(k) >= start_pos) && (PW'(k) <= end_pos);
            lane_insn[k*IW +: IW] = lane_valid[k] ? words[k] : '0;
         end
      end
   end
endmodule

// File: rtl/vliw_packet_dispatcher.sv
module vliw_packet_dispatcher
   import vliw_disp_pkg::*;
#(
   parameter int SLOTS  = 8,
   parameter int IW     = 32,
   parameter bit PACKED = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   output logic                  fetch_req,
   input  logic                  fetch_valid,
   input  logic [SLOTS*IW-1:0]   fetch_data,
   input  logic                  issue_ready,
   output logic [SLOTS-1:0]      issue_valid,
   output logic [SLOTS*IW-1:0]   issue_insn,
   output logic                  chain_error
);
   localparam int PW = $clog2(SLOTS);
   localparam int CW = PW + 1;
   localparam int LAST = SLOTS - 1;

   if (SLOTS < 2) begin : g_bad_slots
      $error("SLOTS must be at least 2");
   end
   if (IW < 2) begin : g_bad_iw
      $error("IW must be at least 2");
   end

   disp_state_e       state;
   logic [PW-1:0]     pos;
   logic [PW-1:0]     end_pos;
   logic [CW-1:0]     count;
   logic [SLOTS-1:0]  chain_bits;
   logic [SLOTS*IW-1:0] held_data;
   logic              err_q;
   logic              load;
   logic              active;

   assign active    = (state == ST_ISSUE);
   assign load      = (state == ST_FETCH) && fetch_valid;
   assign fetch_req = (state == ST_FETCH);
   assign chain_error = err_q;

   vdisp_fetch_buffer #(.SLOTS(SLOTS), .IW(IW)) u_buf (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (load),
      .load_data  (fetch_data),
      .held_data  (held_data),
      .chain_bits (chain_bits)
   );

   vdisp_boundary #(.SLOTS(SLOTS), .PW(PW), .CW(CW)) u_bnd (
      .chain_bits (chain_bits),
      .start_pos  (pos),
      .end_pos    (end_pos),
      .count      (count)
   );

   vdisp_lane_map #(.SLOTS(SLOTS), .IW(IW), .PACKED(PACKED), .PW(PW), .CW(CW)) u_map (
      .held_data  (held_data),
      .start_pos  (pos),
      .end_pos    (end_pos),
      .count      (count),
      .active     (active),
      .lane_valid (issue_valid),
      .lane_insn  (issue_insn)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= ST_FETCH;
         pos   <= '0;
         err_q <= 1'b0;
      end else begin
         case (state)
            ST_FETCH: begin
               if (fetch_valid) begin
                  state <= ST_ISSUE;
                  pos   <= '0;
                  err_q <= fetch_data[LAST*IW];
               end
            end
            ST_ISSUE: begin
               if (issue_ready) begin
                  if (end_pos == PW'(LAST)) begin
                     state <= ST_FETCH;
                     pos   <= '0;
                     err_q <= 1'b0;
                  end else begin
                     pos <= end_pos + PW'(1);
                  end
               end
            end
            default: state <= ST_FETCH;
         endcase
      end
   end

   AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
      !(fetch_req && (|issue_valid))); // R7
   AST_FIRST_PACKET: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_req && fetch_valid) |=> (issue_valid[0] && !fetch_req)); // R2
   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      ((|issue_valid) && !issue_ready) |=> ($stable(issue_valid) && $stable(issue_insn))); // R8
   AST_ERR_WHILE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      chain_error |-> !fetch_req); // R6
   AST_CONTIG_LANES: assert property (@(posedge clk) disable iff (!rst_n)
      !PACKED || ((issue_valid & (issue_valid + SLOTS'(1))) == '0)); // R4
endmodule

// File: tb/vliw_packet_dispatcher_bench.sv
`timescale 1ns/1ps
module vliw_packet_dispatcher_bench;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         fetch_req;
   logic         fetch_valid = 1'b0;
   logic [255:0] fetch_data = '0;
   logic         issue_ready = 1'b0;
   logic [7:0]   issue_valid;
   logic [255:0] issue_insn;
   logic         chain_error;

   int compared = 0;
   int mismatched = 0;
   int cycles = 0;

   always #10 clk = ~clk;

   vliw_packet_dispatcher u_vliw_packet_dispatcher (
      .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .fetch_valid(fetch_valid),
      .fetch_data(fetch_data), .issue_ready(issue_ready), .issue_valid(issue_valid),
      .issue_insn(issue_insn), .chain_error(chain_error)
   );

   task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
      compared++;
      if (!ok) begin
         mismatched++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] word_of(input int p, input int s);
      logic [7:0] pb;
      pb = 8'(p);
      return {8'hA5 ^ pb, 8'(s), 15'(p * 7 + s), pb[s]};
   endfunction

   function automatic logic [255:0] group_of(input int p);
      logic [255:0] g;
      for (int s = 0; s < 8; s++) g[s*32 +: 32] = word_of(p, s);
      return g;
   endfunction

   task automatic check_packet(input int p, input int pos, input string tag);
      logic [7:0]   pb;
      logic [7:0]   ev;
      logic [255:0] ei;
      int e;
      pb = 8'(p);
      e = pos;
      while (e < 7 && pb[e]) e++;
      ev = '0;
      ei = '0;
      for (int k = 0; k <= e - pos; k++) begin
         ev[k] = 1'b1;
         ei[k*32 +: 32] = word_of(p, pos + k);
      end
      chk(issue_valid == ev, {tag, " R4 lane valid"}, 256'(issue_valid), 256'(ev));
      chk(issue_insn == ei, {tag, " R3/R4 lane words"}, issue_insn, ei);
      chk(fetch_req == 1'b0, {tag, " R7 no request mid-group"}, 256'(fetch_req), 256'(0));
      chk(chain_error == pb[7], {tag, " R6 chain error"}, 256'(chain_error), 256'(pb[7]));
   endtask

   task automatic run_pattern(input int p);
      logic [7:0] pb;
      int pos;
      int e;
      bit stalled;
      bit done;
      pb = 8'(p);
      chk(fetch_req == 1'b1 && issue_valid == 8'h00, "R7 request before group",
          256'({fetch_req, issue_valid}), 256'(9'h100));
      fetch_valid = 1'b1;
      fetch_data  = group_of(p);
      issue_ready = 1'b0;
      @(negedge clk);
      fetch_valid = 1'b0;
      pos = 0;
      done = 1'b0;
      stalled = 1'b0;
      while (!done) begin
         check_packet(p, pos, stalled ? "R8 after stall" : "R2/R5 packet");
         e = pos;
         while (e < 7 && pb[e]) e++;
         if (!stalled && ((p + pos) % 3 == 0)) begin
            stalled = 1'b1;
            issue_ready = 1'b0;
            fetch_valid = 1'b1;          // R9 stray fetch while dispatching
            fetch_data  = ~group_of(p);
            @(negedge clk);
            fetch_valid = 1'b0;
         end else begin
            stalled = 1'b0;
            issue_ready = 1'b1;
            @(negedge clk);
            issue_ready = 1'b0;
            if (e == 7) done = 1'b1;
            else pos = e + 1;
         end
      end
   endtask

   initial begin
      @(negedge clk);
      chk(fetch_req == 1'b1, "R1 request in reset", 256'(fetch_req), 256'(1));
      chk(issue_valid == 8'h00, "R1 no valid in reset", 256'(issue_valid), 256'(0));
      chk(chain_error == 1'b0, "R1 error clear in reset", 256'(chain_error), 256'(0));
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(fetch_req == 1'b1 && issue_valid == 8'h00, "R1 after reset",
          256'({fetch_req, issue_valid}), 256'(9'h100));
      for (int p = 0; p < 256; p++) run_pattern(p);
      // R1: reset in the middle of a group
      fetch_valid = 1'b1;
      fetch_data  = group_of(8'h81);
      @(negedge clk);
      fetch_valid = 1'b0;
      check_packet(8'h81, 0, "R2 pre-reset packet");
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      chk(fetch_req == 1'b1 && issue_valid == 8'h00 && chain_error == 1'b0, "R1 mid-group reset",
          256'({fetch_req, issue_valid, chain_error}), 256'(10'h200));
      @(negedge clk);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 150000) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
         end
      end
   end
endmodule